// File: doc/BRIEF.md
# Cassette Controller Host Command and Status Interface

This block is the host-facing side of a controller for two cassette drives. The host issues one I/O operation per cycle. Each operation is a 3-bit code with an accumulator word. The block answers in the same cycle with a skip indication and a returned accumulator value. It keeps an 8-bit command register, a set of sticky error flags, a data flag and a rewind flag. From these and the live state of the selected drive it assembles a 9-bit status word, and it drives one level-sensitive interrupt request.

Tape motion, byte transfer and CRC generation belong to a separate transfer sequencer. The sequencer reports to this block through a data-flag strobe, error strobes and a read-data byte. When the host issues "go", this block decides whether a new operation starts, whether it is refused, or whether the operation in progress continues. It then hands the sequencer a go strobe together with the latched function code, the unit and a data byte.

Top module: `cass_host_if`

## Requirements
- R1: Operation code 0 (clear) zeroes the command register, all error flags, the data flag and the rewind flag. After reset the same state holds, so an operation code 7 returns 0.
- R2: Operation code 4 loads the command register from `acc_i[7:0]` and returns the bitwise complement of `acc_i[7:0]` with the upper accumulator bits zero. Command fields: bit 7 enable, bit 6 unit, bits 5:3 function, bit 0 interrupt enable.
- R3: Operation code 7 returns bits 7:0 of the visible status word, zero-extended. The visible status word is all zero while the command enable bit is clear.
- R4: The status word is laid out as follows: bit 8 write-lock error, 7 CRC error, 6 timing error, 5 tape end, 4 end of file, 3 empty, 2 rewinding, 1 write-locked, 0 ready. Four of these bits follow the selected drive live. Empty is set when the drive is not attached. Ready is set when the drive is not busy. Rewinding is the rewind flag while the drive is attached and busy. Write-locked is set when the drive is unattached, write-protected or rewinding.
- R5: Skips: code 1 skips on the data flag. Code 2 skips when any of status bits 8:3 is set. Code 3 skips when ready is set and empty is clear. Code 5 skips on the data flag, any of bits 8:3, or ready. Other codes never skip.
- R6: `irq_o` is high exactly when interrupt enable is set and the data flag, any of status bits 8:3 or the ready bit of the visible word is set.
- R7: A `seq_df_i` strobe sets the data flag, and a go operation (code 6) clears it. A strobe that arrives while the flag is already set, with no go in the same cycle, sets the timing error.
- R8: A go with no drive busy, enable set and the selected drive attached is a start. A start clears status bits 8:4 and the rewind flag, sets the rewind flag for function 1, and pulses `go_o` with `go_cont_o` low and the command's function and unit.
- R9: A start of function 2 or 4 on a write-protected drive sets the write-lock error and produces no `go_o`.
- R10: A go with no drive busy and either enable clear or the selected drive unattached produces no `go_o` and changes no state except clearing the data flag.
- R11: A go while any drive is busy is a continue: `go_o` and `go_cont_o` pulse high and no error flag is cleared.
- R12: A go returns an accumulator that depends on the function. For function 0 or 6 it returns 0 on a start or refusal and `seq_rdata_i` on a continue. For every other function, and on idle cycles, it returns `acc_i` unchanged.
- R13: Each bit of `seq_err_i` sets its sticky error flag: bit 4 write-lock error, 3 CRC, 2 timing, 1 tape end, 0 end of file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation is issued this cycle |
| op_i | input | 3 | Operation code |
| acc_i | input | ACC_W | Accumulator value from the host |
| acc_o | output | ACC_W | Accumulator value returned to the host |
| skip_o | output | 1 | Skip condition for the current operation |
| irq_o | output | 1 | Level interrupt request |
| drv_att_i | input | 2 | Per-drive attached |
| drv_wprot_i | input | 2 | Per-drive write-protected |
| drv_busy_i | input | 2 | Per-drive busy |
| seq_rdata_i | input | 8 | Byte offered by the sequencer on read |
| seq_df_i | input | 1 | Sequencer sets the data flag |
| seq_err_i | input | 5 | Sequencer error set strobes |
| go_o | output | 1 | Go strobe to the sequencer |
| go_cont_o | output | 1 | Go continues the operation in progress |
| go_fn_o | output | 3 | Function code for the sequencer |
| go_unit_o | output | 1 | Selected unit |
| go_data_o | output | 8 | Data byte for write functions |

## Verification
The first set of patterns is the command field encodings under each combination of attached, write-protected and busy drive state. These show that the live status bits are selected per drive and that status is hidden while enable is clear. Go is issued in four situations: enabled and attached, write-protected with a write function, not enabled or unattached, and while either drive is busy. Together these separate start, refusal, write-lock block and continue, each of which has its own returned value. Back-to-back data-flag strobes, with and without an intervening go, distinguish a timing error from a normal handshake. A long stretch of randomized operations, drive states and sequencer strobes is compared cycle by cycle against a behavioural model.

// File: rtl/cass_pkg.sv
package cass_pkg;
  localparam int CMD_W  = 8;
  localparam int ST_W   = 9;
  localparam int ERR_W  = 5;
  localparam int UNIT_W = 1;
  localparam int NUM_DRIVES = 2 ** UNIT_W;
  localparam int BYTE_W = 8;

  // command register fields
  localparam int CB_EN    = 7;
  localparam int CB_UNIT  = 6;
  localparam int CB_FN_LO = 3;
  localparam int CB_IE    = 0;

  // status word bit positions
  localparam int SB_WLE   = 8;
  localparam int SB_CRC   = 7;
  localparam int SB_TIM   = 6;
  localparam int SB_TEND  = 5;
  localparam int SB_EOF   = 4;
  localparam int SB_EMPTY = 3;
  localparam int SB_REW   = 2;
  localparam int SB_WLK   = 1;
  localparam int SB_RDY   = 0;
  localparam int ERR_LO   = SB_EOF;

  typedef enum logic [2:0] {
    OP_CLEAR    = 3'd0,
    OP_SKIP_DF  = 3'd1,
    OP_SKIP_ERR = 3'd2,
    OP_SKIP_RDY = 3'd3,
    OP_LOAD_CMD = 3'd4,
    OP_SKIP_ANY = 3'd5,
    OP_GO       = 3'd6,
    OP_READ_ST  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    FN_READ     = 3'd0,
    FN_REWIND   = 3'd1,
    FN_WRITE    = 3'd2,
    FN_SP_RFILE = 3'd3,
    FN_WR_GAP   = 3'd4,
    FN_SP_RBLK  = 3'd5,
    FN_CRC      = 3'd6,
    FN_SP_FFILE = 3'd7
  } fn_e;

  function automatic logic is_write_fn(fn_e f);
    return (f == FN_WRITE) || (f == FN_WR_GAP);
  endfunction

  function automatic logic returns_data(fn_e f);
    return (f == FN_READ) || (f == FN_CRC);
  endfunction
endpackage

// File: rtl/cass_cmd_reg.sv
module cass_cmd_reg
  import cass_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                load_i,
  input  logic [CMD_W-1:0]    din_i,
  output logic                en_o,
  output logic [UNIT_W-1:0]   unit_o,
  output logic [2:0]          fn_o,
  output logic                ie_o
);
  logic [CMD_W-1:0] a_q;
  logic             unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     a_q <= '0;
    else if (clr_i)  a_q <= '0;
    else if (load_i) a_q <= din_i;
  end

  assign en_o        = a_q[CB_EN];
  assign unit_o      = a_q[CB_UNIT -: UNIT_W];
  assign fn_o        = a_q[CB_FN_LO +: 3];
  assign ie_o        = a_q[CB_IE];
  assign unused_bits = ^a_q[2:1];

  AST_CMD_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!en_o && !ie_o && fn_o == 3'd0)); // R1
endmodule

// File: rtl/cass_status.sv
module cass_status
  import cass_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              start_blk_i,
  input  logic              start_rew_i,
  input  logic              go_i,
  input  logic              seq_df_i,
  input  logic [ERR_W-1:0]  seq_err_i,
  input  logic              en_i,
  input  logic              att_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ST_W-1:0]   vis_o,
  output logic              df_o
);
  localparam int E_WLE = SB_WLE - ERR_LO;
  localparam int E_TIM = SB_TIM - ERR_LO;

  logic [ERR_W-1:0] err_q, err_n;
  logic             df_q, df_n;
  logic             rew_q, rew_n;
  logic             overrun;
  logic             rew_live, wlk_live;
  logic [ST_W-1:0]  st_word;

  assign overrun = seq_df_i & df_q & ~go_i;

  always_comb begin
    err_n = err_q;
    rew_n = rew_q;
    if (start_i) begin
      err_n = '0;
      rew_n = start_rew_i;
    end
    if (start_blk_i) err_n[E_WLE] = 1'b1;
    if (overrun)     err_n[E_TIM] = 1'b1;
    err_n = err_n | seq_err_i;
    // a new strobe wins over a go in the same cycle
    df_n  = seq_df_i | (df_q & ~go_i);
    if (clr_i) begin
      err_n = '0;
      rew_n = 1'b0;
      df_n  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      df_q  <= 1'b0;
      rew_q <= 1'b0;
    end else begin
      err_q <= err_n;
      df_q  <= df_n;
      rew_q <= rew_n;
    end
  end

  assign rew_live = rew_q & att_i & busy_i;
  assign wlk_live = ~att_i | wp_i | rew_live;
  assign st_word  = {err_q, ~att_i, rew_live, wlk_live, ~busy_i};
  assign vis_o    = en_i ? st_word : '0;
  assign df_o     = df_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!df_q && err_q == '0 && !rew_q)); // R1
  AST_GO_DROPS_DF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !seq_df_i) |=> !df_q); // R7
  AST_OVERRUN_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_df_i && df_q && !go_i && !clr_i) |=> err_q[E_TIM]); // R7
  AST_START_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !start_blk_i && seq_err_i == '0 && !seq_df_i && !clr_i) |=> err_q == '0); // R8
  AST_WLE_ON_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_blk_i && !clr_i) |=> err_q[E_WLE]); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !clr_i) |=> ((err_q & $past(err_q)) == $past(err_q))); // R13
endmodule

// File: rtl/cass_op_decode.sv
module cass_op_decode
  import cass_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ST_W-1:0]   vis_i,
  input  logic              df_i,
  input  logic              en_i,
  input  logic              att_i,
  input  logic              wp_i,
  input  logic              any_busy_i,
  input  logic [2:0]        fn_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              skip_o,
  output logic              clr_o,
  output logic              load_o,
  output logic              go_op_o,
  output logic              start_o,
  output logic              start_blk_o,
  output logic              start_rew_o,
  output logic              go_o,
  output logic              go_cont_o
);
  localparam int PAD_W = ACC_W - BYTE_W;

  op_e  op;
  fn_e  fn;
  logic err_any, rdy, empty;

  assign op      = op_e'(op_i);
  assign fn      = fn_e'(fn_i);
  assign err_any = |vis_i[SB_WLE:SB_EMPTY];
  assign rdy     = vis_i[SB_RDY];
  assign empty   = vis_i[SB_EMPTY];

  assign clr_o       = op_valid_i && op == OP_CLEAR;
  assign load_o      = op_valid_i && op == OP_LOAD_CMD;
  assign go_op_o     = op_valid_i && op == OP_GO;
  assign go_cont_o   = go_op_o & any_busy_i;
  assign start_o     = go_op_o & ~any_busy_i & en_i & att_i;
  assign start_blk_o = start_o & is_write_fn(fn) & wp_i;
  assign start_rew_o = fn == FN_REWIND;
  assign go_o        = go_cont_o | (start_o & ~start_blk_o);

  always_comb begin
    acc_o  = acc_i;
    skip_o = 1'b0;
    if (op_valid_i) begin
      unique case (op)
        OP_SKIP_DF:  skip_o = df_i;
        OP_SKIP_ERR: skip_o = err_any;
        OP_SKIP_RDY: skip_o = rdy & ~empty;
        OP_SKIP_ANY: skip_o = df_i | err_any | rdy;
        OP_LOAD_CMD: acc_o  = {{PAD_W{1'b0}}, ~acc_i[BYTE_W-1:0]};
        OP_READ_ST:  acc_o  = {{PAD_W{1'b0}}, vis_i[BYTE_W-1:0]};
        OP_GO: if (returns_data(fn))
                 acc_o = any_busy_i ? {{PAD_W{1'b0}}, rdata_i} : '0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cass_host_if.sv
module cass_host_if
  import cass_pkg::*;
#(
  parameter int ACC_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_valid_i,
  input  logic [2:0]            op_i,
  input  logic [ACC_W-1:0]      acc_i,
  output logic [ACC_W-1:0]      acc_o,
  output logic                  skip_o,
  output logic                  irq_o,
  input  logic [NUM_DRIVES-1:0] drv_att_i,
  input  logic [NUM_DRIVES-1:0] drv_wprot_i,
  input  logic [NUM_DRIVES-1:0] drv_busy_i,
  input  logic [BYTE_W-1:0]     seq_rdata_i,
  input  logic                  seq_df_i,
  input  logic [ERR_W-1:0]      seq_err_i,
  output logic                  go_o,
  output logic                  go_cont_o,
  output logic [2:0]            go_fn_o,
  output logic [UNIT_W-1:0]     go_unit_o,
  output logic [BYTE_W-1:0]     go_data_o
);
  logic              en, ie, df;
  logic [UNIT_W-1:0] unit;
  logic [2:0]        fn;
  logic [ST_W-1:0]   vis;
  logic              clr, load, go_op, start, start_blk, start_rew;
  logic              att_sel, wp_sel, busy_sel, any_busy;

  assign att_sel  = drv_att_i[unit];
  assign wp_sel   = drv_wprot_i[unit];
  assign busy_sel = drv_busy_i[unit];
  assign any_busy = |drv_busy_i;

  cass_cmd_reg u_cmd (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr), .load_i (load),
    .din_i (acc_i[CMD_W-1:0]),
    .en_o (en), .unit_o (unit), .fn_o (fn), .ie_o (ie)
  );

  cass_status u_status (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (clr),
    .start_i (start), .start_blk_i (start_blk), .start_rew_i (start_rew),
    .go_i (go_op), .seq_df_i (seq_df_i), .seq_err_i (seq_err_i),
    .en_i (en), .att_i (att_sel), .wp_i (wp_sel), .busy_i (busy_sel),
    .vis_o (vis), .df_o (df)
  );

  cass_op_decode #(.ACC_W (ACC_W)) u_dec (
    .op_valid_i (op_valid_i), .op_i (op_i), .acc_i (acc_i),
    .vis_i (vis), .df_i (df), .en_i (en), .att_i (att_sel), .wp_i (wp_sel),
    .any_busy_i (any_busy), .fn_i (fn), .rdata_i (seq_rdata_i),
    .acc_o (acc_o), .skip_o (skip_o), .clr_o (clr), .load_o (load),
    .go_op_o (go_op), .start_o (start), .start_blk_o (start_blk),
    .start_rew_o (start_rew), .go_o (go_o), .go_cont_o (go_cont_o)
  );

  assign irq_o     = ie & (df | (|vis[SB_WLE:SB_EMPTY]) | vis[SB_RDY]);
  assign go_fn_o   = fn;
  assign go_unit_o = unit;
  assign go_data_o = acc_i[BYTE_W-1:0];

  AST_NO_GO_PROTECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !go_cont_o) |-> !(is_write_fn(fn_e'(go_fn_o)) && drv_wprot_i[go_unit_o])); // R9
  AST_START_NEEDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !go_cont_o) |-> (en && drv_att_i[go_unit_o] && !any_busy)); // R10
  AST_CONT_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_cont_o |-> (go_o && any_busy)); // R11
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie); // R6
endmodule

// File: tb/cass_host_if_tb_top.sv
`timescale 1ns/1ps
module cass_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t_v = 1'b0;
  logic [2:0]  t_op = 3'd0;
  logic [11:0] t_acc = '0;
  logic [1:0]  t_att = '0, t_wp = '0, t_busy = '0;
  logic [7:0]  t_rd = '0;
  logic        t_sdf = 1'b0;
  logic [4:0]  t_serr = '0;

  logic [11:0] acc_o;
  logic        skip_o, irq_o, go_o, go_cont_o, go_unit_o;
  logic [2:0]  go_fn_o;
  logic [7:0]  go_data_o;

  integer n_chk = 0, n_err = 0;

  // reference state
  logic [7:0] m_a;
  logic [4:0] m_err;
  logic       m_df, m_rew;

  always #2 clk = ~clk;

  cass_host_if #(.ACC_W (12)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .op_valid_i (t_v), .op_i (t_op),
    .acc_i (t_acc), .acc_o (acc_o), .skip_o (skip_o), .irq_o (irq_o),
    .drv_att_i (t_att), .drv_wprot_i (t_wp), .drv_busy_i (t_busy),
    .seq_rdata_i (t_rd), .seq_df_i (t_sdf), .seq_err_i (t_serr),
    .go_o (go_o), .go_cont_o (go_cont_o), .go_fn_o (go_fn_o),
    .go_unit_o (go_unit_o), .go_data_o (go_data_o)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [8:0] m_vis();
    logic s, att, busy;
    logic rew;
    s = m_a[6];
    att = t_att[s];
    busy = t_busy[s];
    rew = m_rew && att && busy;
    if (!m_a[7]) return 9'd0;
    return {m_err, !att, rew, (!att || t_wp[s] || rew), !busy};
  endfunction

  task automatic cmp();
    logic [8:0] vis;
    logic [11:0] e_acc;
    logic e_skip, e_irq, e_go, e_cont, errs, strt, blk;
    logic [2:0] fn;
    string tg, gtag;
    vis = m_vis();
    fn = m_a[5:3];
    errs = |vis[8:3];
    e_acc = t_acc; e_skip = 0; e_go = 0; e_cont = 0;
    tg = "R12"; gtag = "R8";
    strt = 0; blk = 0;
    if (t_v) begin
      case (t_op)
        3'd0: tg = "R1";
        3'd1: begin e_skip = m_df; tg = "R5"; end
        3'd2: begin e_skip = errs; tg = "R5"; end
        3'd3: begin e_skip = vis[0] && !vis[3]; tg = "R5"; end
        3'd4: begin e_acc = {4'd0, ~t_acc[7:0]}; tg = "R2"; end
        3'd5: begin e_skip = m_df || errs || vis[0]; tg = "R5"; end
        3'd7: begin e_acc = {4'd0, vis[7:0]}; tg = "R3"; end
        default: begin
          if (|t_busy) begin
            e_go = 1; e_cont = 1; gtag = "R11";
            if (fn == 0 || fn == 6) e_acc = {4'd0, t_rd};
          end else begin
            strt = m_a[7] && t_att[m_a[6]];
            blk = strt && (fn == 2 || fn == 4) && t_wp[m_a[6]];
            e_go = strt && !blk;
            gtag = blk ? "R9" : (strt ? "R8" : "R10");
            if (fn == 0 || fn == 6) e_acc = 12'd0;
          end
        end
      endcase
    end
    e_irq = m_a[0] && (m_df || errs || vis[0]);
    check(acc_o === e_acc, tg, acc_o, e_acc);
    check(skip_o === e_skip, "R5", skip_o, e_skip);
    check(irq_o === e_irq, "R6", irq_o, e_irq);
    check(go_o === e_go, gtag, go_o, e_go);
    if (e_go) begin
      check(go_cont_o === e_cont, gtag, go_cont_o, e_cont);
      check({go_fn_o, go_unit_o} === {fn, m_a[6]}, gtag, {go_fn_o, go_unit_o}, {fn, m_a[6]});
      check(go_data_o === t_acc[7:0], gtag, go_data_o, t_acc[7:0]);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic gop, strt, wr;
    logic [2:0] fn;
    if (!rst_n) begin
      m_a = 0; m_err = 0; m_df = 0; m_rew = 0;
    end else if (t_v && t_op == 3'd0) begin
      m_a = 0; m_err = 0; m_df = 0; m_rew = 0;
    end else begin
      fn = m_a[5:3];
      gop = t_v && t_op == 3'd6;
      strt = gop && !(|t_busy) && m_a[7] && t_att[m_a[6]];
      wr = fn == 2 || fn == 4;
      if (strt) begin
        m_err = 0;
        m_rew = (fn == 1);
        if (wr && t_wp[m_a[6]]) m_err[4] = 1;
      end
      if (t_sdf && m_df && !gop) m_err[2] = 1;
      m_err = m_err | t_serr;
      m_df = t_sdf ? 1'b1 : (gop ? 1'b0 : m_df);
      if (t_v && t_op == 3'd4) m_a = t_acc[7:0];
    end
  end

  task automatic step(input logic v, input logic [2:0] op, input logic [11:0] acc);
    @(negedge clk);
    t_v = v; t_op = op; t_acc = acc; t_sdf = 0; t_serr = 0;
    #1 cmp();
  endtask

  task automatic ev(input logic sdf, input logic [4:0] serr);
    @(negedge clk);
    t_v = 0; t_sdf = sdf; t_serr = serr;
    #1 cmp();
  endtask

  task automatic drv(input logic [1:0] att, input logic [1:0] wp, input logic [1:0] busy);
    @(negedge clk);
    t_v = 0; t_sdf = 0; t_serr = 0;
    t_att = att; t_wp = wp; t_busy = busy;
    #1 cmp();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    step(1, 3'd7, 12'hABC);
    check(acc_o === 12'h000, "R1", acc_o, 12'h000);
    step(1, 3'd5, 12'h0);
    drv(2'b01, 2'b00, 2'b00);
    step(1, 3'd3, 12'h0);
    check(skip_o === 1'b0, "R3", skip_o, 1'b0);

    // R2: load enable, unit 0, read, ie
    step(1, 3'd4, 12'hF81);
    check(acc_o === 12'h07E, "R2", acc_o, 12'h07E);
    step(1, 3'd7, 12'h0);
    check(acc_o === 12'h001, "R4", acc_o, 12'h001);
    check(irq_o === 1'b1, "R6", irq_o, 1'b1);
    step(1, 3'd3, 12'h0);

    // R4: unattached unit 1 -> empty, write-locked, ready
    step(1, 3'd4, 12'h0C1);
    step(1, 3'd7, 12'h0);
    check(acc_o === 12'h00B, "R4", acc_o, 12'h00B);
    step(1, 3'd2, 12'h0);
    step(1, 3'd3, 12'h0);
    // R10: go refused on unattached drive
    step(1, 3'd6, 12'h055);
    check(go_o === 1'b0, "R10", go_o, 1'b0);
    step(1, 3'd4, 12'h000);
    step(1, 3'd6, 12'h055);

    // R8/R12: start a read on unit 0
    step(1, 3'd4, 12'h081);
    step(1, 3'd6, 12'h0AA);
    check(acc_o === 12'h000, "R12", acc_o, 12'h000);
    drv(2'b01, 2'b00, 2'b01);
    t_rd = 8'h5A;
    ev(1, 5'd0);
    step(1, 3'd1, 12'h0);
    check(skip_o === 1'b1, "R7", skip_o, 1'b1);
    step(1, 3'd6, 12'h0);
    check(acc_o === 12'h05A, "R11", acc_o, 12'h05A);
    step(1, 3'd1, 12'h0);
    // R7: overrun sets timing error
    ev(1, 5'd0);
    ev(1, 5'd0);
    step(1, 3'd7, 12'h0);
    check(acc_o[6] === 1'b1, "R7", acc_o[6], 1'b1);
    step(1, 3'd2, 12'h0);

    // R9: write on protected drive
    drv(2'b01, 2'b01, 2'b00);
    step(1, 3'd4, 12'h091);
    step(1, 3'd6, 12'h033);
    check(go_o === 1'b0, "R9", go_o, 1'b0);
    step(1, 3'd2, 12'h0);
    check(skip_o === 1'b1, "R9", skip_o, 1'b1);
    step(1, 3'd7, 12'h0);
    // R8: write start clears errors
    drv(2'b01, 2'b00, 2'b00);
    step(1, 3'd6, 12'h033);
    step(1, 3'd2, 12'h0);
    check(skip_o === 1'b0, "R8", skip_o, 1'b0);

    // R8/R4: rewind shows rewinding and write-locked while busy
    step(1, 3'd4, 12'h089);
    step(1, 3'd6, 12'h0);
    drv(2'b01, 2'b00, 2'b01);
    step(1, 3'd7, 12'h0);
    check(acc_o === 12'h006, "R4", acc_o, 12'h006);
    // R13: sequencer errors
    ev(0, 5'b01001);
    step(1, 3'd7, 12'h0);
    check(acc_o === 12'h096, "R13", acc_o, 12'h096);
    // R11: continue keeps errors, drive 1 busy while unit 0 selected
    drv(2'b11, 2'b00, 2'b10);
    step(1, 3'd6, 12'h0);
    step(1, 3'd2, 12'h0);
    check(skip_o === 1'b1, "R11", skip_o, 1'b1);
    // R1: clear
    step(1, 3'd0, 12'h0);
    step(1, 3'd7, 12'h0);
    check(acc_o === 12'h000, "R1", acc_o, 12'h000);

    // randomized run against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      t_v    = ($urandom % 4) != 0;
      t_op   = 3'($urandom);
      if (t_op == 3'd0 && ($urandom % 4) != 0) t_op = 3'd7;
      t_acc  = 12'($urandom);
      if (($urandom % 4) != 0) t_acc[7] = 1'b1;
      t_sdf  = ($urandom % 6) == 0;
      t_serr = (($urandom % 10) == 0) ? 5'($urandom) : 5'd0;
      t_rd   = 8'($urandom);
      if (($urandom % 8) == 0) begin
        t_att  = 2'($urandom);
        t_wp   = 2'($urandom);
        t_busy = 2'($urandom);
      end
      #1 cmp();
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule